// File: doc/BRIEF.md
# Service slave configuration space decoder

This block sits behind the 32-bit read/write access port of a serial service interface engine and decodes the slave's 2 MiB byte window. The window has three regions. The lowest kilobyte is a read-only configuration table. It starts with a chip identifier, follows with two fixed engine descriptors, and then lists one descriptor word for each attached local-bus device, with a terminating zero word and a sentinel value past that. The slave control registers are at 0x800. Every address from 0xC00 upward belongs to a local-bus window, which is split into per-device sub-windows by base-address parameters.

A write of a magic value to the identifier word sends a single-cycle reset pulse to the attached bus. All other configuration writes are ignored. Accesses to the control window and to the device windows are steered out through one-hot selects, together with the offset inside the selected target. The selected target returns its read data in the same cycle. The block registers that data and returns it one cycle later. All register data crosses the access port in big-endian byte order.

Top module: `svc_cfg_space`

## Requirements
- R1: A legal read of byte address 0x000 returns the identifier 0xC0022D15 in register order.
- R2: Address 0x004 returns 0x8001102C and address 0x008 returns 0x8001503A. Both words use the same field layout: bit 31 is "another entry follows", bits 23:16 hold the slot count (1), bits 15:12 hold the version (1 and 5), bits 11:4 hold the engine type (0x02 peek, 0x03 serial interface), and bits 3:0 hold the check nibble (0xC and 0xA).
- R3: Starting at 0x00C, each word k (address 0x00C+4k, k < N) returns the descriptor input of device k, in device order.
- R4: The word at 0x00C+4N returns 0. Every word from there up to 0x3FC returns 0xC0DE0000.
- R5: A legal write of 0xC0DE0000 to address 0x000 makes bus_reset high for exactly the one cycle after the write is accepted. Any other configuration write leaves bus_reset low and leaves the table contents unchanged.
- R6: Data on the port is byte-swapped relative to register order. Port bits 7:0 carry register bits 31:24, and this applies to both read data and write data. For example, the identifier appears on the port as 0x152D02C0.
- R7: rsp_valid is high in the cycle after every cycle with req_valid high, and is low otherwise.
- R8: An access with req_addr[1:0] != 0, or with req_size other than 2 (2 = 32-bit), returns rsp_err=1 with rsp_rdata=0. It asserts no select and causes no reset. A legal access returns rsp_err=0.
- R9: A legal access in 0x800..0xBFF asserts ctl_sel with win_offset = address - 0x800, and a read returns the port-ordered value of ctl_rdata.
- R10: A legal access in the local-bus window at offset o = address - 0xC00 asserts dev_sel[i] when DEV_BASE_i <= o < DEV_BASE_i + DEV_SPAN. In that case win_offset = o - DEV_BASE_i and a read returns device i's rdata word in port order. An offset that no device claims reads 0 and asserts no select.
- R11: The gap 0x400..0x7FF asserts no select and reads 0. Writes to it have no effect.
- R12: win_write is high during a legal write that hits a window, and win_wdata carries the write data in register order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code; 2 = 32-bit word |
| req_addr | input | 21 | Byte address in the slave window |
| req_wdata | input | 32 | Write data, port byte order |
| rsp_valid | output | 1 | Response valid, one cycle after the strobe |
| rsp_rdata | output | 32 | Read data, port byte order |
| rsp_err | output | 1 | Illegal size or alignment |
| bus_reset | output | 1 | Single-cycle reset pulse to the attached bus |
| ctl_sel | output | 1 | Control window access strobe |
| dev_sel | output | N | Per-device access strobes, one-hot |
| win_write | output | 1 | Window access is a write |
| win_offset | output | 21 | Byte offset inside the selected target |
| win_wdata | output | 32 | Write data, register order |
| ctl_rdata | input | 32 | Control window read data, register order |
| dev_desc | input | 32*N | Device descriptors, device 0 in the low bits |
| dev_rdata | input | 32*N | Device read data, device 0 in the low bits |

## Verification
The bench builds the block with N=3 and the default bases (0x000, 0x400 and 0x800 inside the local-bus window, each 0x400 bytes wide). With N=3 the end of the descriptor list falls at 0x018, which puts both the terminating zero word and the first sentinel word at addresses the bench can reach directly. The bases also leave the local-bus offset 0x1000 unclaimed, so the bench can test a read that hits no device. The gap region and the last table word (0x3FC) are covered as well.

// File: rtl/svc_cfg_space.sv
module svc_cfg_space #(
  parameter int N = 3,
  parameter logic [20:0] DEV_SPAN = 21'h400,
  parameter logic [8*21-1:0] DEV_BASE = {21'h1C00, 21'h1800, 21'h1400, 21'h1000,
                                         21'h0C00, 21'h0800, 21'h0400, 21'h0000}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [1:0]      req_size,
  input  logic [20:0]     req_addr,
  input  logic [31:0]     req_wdata,
  output logic            rsp_valid,
  output logic [31:0]     rsp_rdata,
  output logic            rsp_err,
  output logic            bus_reset,
  output logic            ctl_sel,
  output logic [N-1:0]    dev_sel,
  output logic            win_write,
  output logic [20:0]     win_offset,
  output logic [31:0]     win_wdata,
  input  logic [31:0]     ctl_rdata,
  input  logic [32*N-1:0] dev_desc,
  input  logic [32*N-1:0] dev_rdata
);
  localparam logic [20:0] CFG_END  = 21'h000400;
  localparam logic [20:0] CTL_BASE = 21'h000800;
  localparam logic [20:0] LB_BASE  = 21'h000C00;
  localparam logic [31:0] CHIP_ID  = 32'hC0022D15;
  localparam logic [31:0] BRK_VAL  = 32'hC0DE0000;
  localparam logic [31:0] DESC_PK  = 32'h8001102C;
  localparam logic [31:0] DESC_SI  = 32'h8001503A;

  function automatic logic [31:0] swap(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  logic legal, in_cfg, in_ctl, in_lb, brk;
  logic [20:0] lb_off;
  logic [31:0] wdat, cfg_val, dev_val, rd_val;
  logic [20:0] dev_off;
  int unsigned widx;

  assign legal  = req_valid && req_addr[1:0] == 2'd0 && req_size == 2'd2;
  assign in_cfg = req_addr < CFG_END;
  assign in_ctl = req_addr >= CTL_BASE && req_addr < LB_BASE;
  assign in_lb  = req_addr >= LB_BASE;
  assign lb_off = req_addr - LB_BASE;
  assign wdat   = swap(req_wdata);
  assign widx   = {24'd0, req_addr[9:2]};

  for (genvar i = 0; i < N; i++) begin : g_dev
    localparam logic [21:0] LO = {1'b0, DEV_BASE[21*i +: 21]};
    localparam logic [21:0] HI = LO + {1'b0, DEV_SPAN};
    assign dev_sel[i] = legal && in_lb && {1'b0, lb_off} >= LO && {1'b0, lb_off} < HI;
  end

  always_comb begin
    dev_val = '0;
    dev_off = '0;
    for (int i = 0; i < N; i++)
      if (dev_sel[i]) begin
        dev_val = dev_rdata[32*i +: 32];
        dev_off = lb_off - DEV_BASE[21*i +: 21];
      end
  end

  always_comb begin
    if (widx == 0)           cfg_val = CHIP_ID;
    else if (widx == 1)      cfg_val = DESC_PK;
    else if (widx == 2)      cfg_val = DESC_SI;
    else if (widx == 3 + N)  cfg_val = '0;
    else                     cfg_val = BRK_VAL;
    for (int i = 0; i < N; i++)
      if (widx == 3 + i) cfg_val = dev_desc[32*i +: 32];
  end

  assign ctl_sel    = legal && in_ctl;
  assign win_write  = req_write && (ctl_sel || |dev_sel);
  assign win_offset = ctl_sel ? req_addr - CTL_BASE : dev_off;
  assign win_wdata  = wdat;
  assign brk        = legal && req_write && req_addr == 21'd0 && wdat == BRK_VAL;

  always_comb begin
    if (!legal || req_write) rd_val = '0;
    else if (in_cfg)         rd_val = cfg_val;
    else if (ctl_sel)        rd_val = ctl_rdata;
    else if (|dev_sel)       rd_val = dev_val;
    else                     rd_val = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      bus_reset <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !legal;
      rsp_rdata <= swap(rd_val);
      bus_reset <= brk;
    end
  end
endmodule

module svc_cfg_space_chk #(parameter int N = 3) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         req_write,
  input logic [1:0]   req_size,
  input logic [20:0]  req_addr,
  input logic [31:0]  req_wdata,
  input logic         rsp_valid,
  input logic [31:0]  rsp_rdata,
  input logic         rsp_err,
  input logic         bus_reset,
  input logic         ctl_sel,
  input logic [N-1:0] dev_sel
);
  p_break_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |-> $past(req_valid && req_write && req_size == 2'd2 &&
                        req_addr == 21'd0 && req_wdata == 32'h0000DEC0));
  p_break_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !bus_reset);
  p_rsp_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_rsp_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_err_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_rdata == 32'd0);
  p_misalign_nosel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_addr[1:0] != 2'd0 || req_size != 2'd2)) |-> (!ctl_sel && dev_sel == '0));
  p_sel_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl_sel, dev_sel}));
endmodule

bind svc_cfg_space svc_cfg_space_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
  .bus_reset(bus_reset), .ctl_sel(ctl_sel), .dev_sel(dev_sel));

// File: tb/sim_svc_cfg_space.sv
module sim_svc_cfg_space;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_size = 2'd2;
  logic [20:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_err, bus_reset, ctl_sel, win_write;
  logic [31:0] rsp_rdata, win_wdata, ctl_rdata;
  logic [N-1:0] dev_sel;
  logic [20:0] win_offset;
  logic [32*N-1:0] dev_desc, dev_rdata;

  int errors = 0, checks = 0;
  logic [N-1:0] s_dev;
  logic s_ctl, s_ww;
  logic [20:0] s_off;
  logic [31:0] s_wd;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign dev_desc  = {32'h33330003, 32'h22220002, 32'h11110001};
  assign dev_rdata = {32'hD0D00003, 32'hD0D00002, 32'hD0D00001};
  assign ctl_rdata = ctl_sel ? 32'h11223344 : 32'hDEADBEEF;

  svc_cfg_space #(.N(N)) u0 (.*);

  function automatic logic [31:0] bs(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [1:0] sz, input logic [20:0] a, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    #1;
    s_dev = dev_sel; s_ctl = ctl_sel; s_off = win_offset; s_ww = win_write; s_wd = win_wdata;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_size = 2'd2;
  endtask

  task automatic rd(input logic [20:0] a, input logic [31:0] reg_exp, input string req);
    acc(1'b0, 2'd2, a, '0);
    chk(req, rsp_rdata, bs(reg_exp));
    chk(req, {31'd0, rsp_err}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R7 reset valid", {31'd0, rsp_valid}, 0);
    chk("R5 reset pulse", {31'd0, bus_reset}, 0);
  endtask

  task automatic t_ident;
    rd(21'h000, 32'hC0022D15, "R1 id");
    acc(1'b0, 2'd2, 21'h000, '0);
    chk("R6 id port order", rsp_rdata, 32'h152D02C0);
  endtask

  task automatic t_fixed;
    rd(21'h004, 32'h8001102C, "R2 peek desc");
    rd(21'h008, 32'h8001503A, "R2 serial desc");
  endtask

  task automatic t_devlist;
    rd(21'h00C, 32'h11110001, "R3 dev0");
    rd(21'h010, 32'h22220002, "R3 dev1");
    rd(21'h014, 32'h33330003, "R3 dev2");
  endtask

  task automatic t_tail;
    rd(21'h018, 32'h0, "R4 end word");
    rd(21'h01C, 32'hC0DE0000, "R4 sentinel");
    rd(21'h3FC, 32'hC0DE0000, "R4 last sentinel");
  endtask

  task automatic t_break;
    acc(1'b1, 2'd2, 21'h000, 32'h0000DEC0);
    chk("R5 pulse", {31'd0, bus_reset}, 1);
    @(negedge clk);
    chk("R5 pulse width", {31'd0, bus_reset}, 0);
    acc(1'b1, 2'd2, 21'h000, 32'h12345678);
    chk("R5 other value", {31'd0, bus_reset}, 0);
    acc(1'b1, 2'd2, 21'h004, 32'h0000DEC0);
    chk("R5 other word", {31'd0, bus_reset}, 0);
    rd(21'h000, 32'hC0022D15, "R5 id unchanged");
  endtask

  task automatic t_timing;
    acc(1'b0, 2'd2, 21'h004, '0);
    chk("R7 valid after strobe", {31'd0, rsp_valid}, 1);
    @(negedge clk);
    chk("R7 idle", {31'd0, rsp_valid}, 0);
  endtask

  task automatic t_illegal;
    acc(1'b0, 2'd2, 21'h002, '0);
    chk("R8 misalign err", {31'd0, rsp_err}, 1);
    chk("R8 misalign data", rsp_rdata, 0);
    acc(1'b0, 2'd0, 21'h000, '0);
    chk("R8 size err", {31'd0, rsp_err}, 1);
    chk("R8 size data", rsp_rdata, 0);
    acc(1'b1, 2'd1, 21'h000, 32'h0000DEC0);
    chk("R8 no break", {31'd0, bus_reset}, 0);
    acc(1'b0, 2'd0, 21'h810, '0);
    chk("R8 no sel", {30'd0, s_ctl, |s_dev}, 0);
  endtask

  task automatic t_ctl;
    rd(21'h810, 32'h11223344, "R9 ctl data");
    chk("R9 ctl sel", {31'd0, s_ctl}, 1);
    chk("R9 ctl offset", {11'd0, s_off}, 32'h10);
  endtask

  task automatic t_dev;
    rd(21'h1008, 32'hD0D00002, "R10 dev1 data");
    chk("R10 dev1 sel", {29'd0, s_dev}, 32'b010);
    chk("R10 dev1 offset", {11'd0, s_off}, 32'h8);
    rd(21'h1400, 32'hD0D00003, "R10 dev2 data");
    chk("R10 dev2 sel", {29'd0, s_dev}, 32'b100);
    rd(21'h1C00, 32'h0, "R10 unclaimed");
    chk("R10 unclaimed sel", {29'd0, s_dev}, 0);
  endtask

  task automatic t_gap;
    rd(21'h500, 32'h0, "R11 gap read");
    chk("R11 gap sel", {30'd0, s_ctl, |s_dev}, 0);
    acc(1'b1, 2'd2, 21'h500, 32'h0000DEC0);
    chk("R11 gap write", {30'd0, bus_reset, s_ww}, 0);
  endtask

  task automatic t_wr;
    acc(1'b1, 2'd2, 21'h0C04, 32'hAABBCCDD);
    chk("R12 win write", {31'd0, s_ww}, 1);
    chk("R12 win data", s_wd, 32'hDDCCBBAA);
    chk("R12 dev0 sel", {29'd0, s_dev}, 32'b001);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_ident; t_fixed; t_devlist; t_tail; t_break;
    t_timing; t_illegal; t_ctl; t_dev; t_gap; t_wr;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule